// File: doc/BRIEF.md
# Single/Double Tap Detector

The block watches a stream of signed three-axis acceleration samples and classifies short spikes on each axis as taps. A new sample arrives with a one-clock valid strobe at the output data rate. Every timing quantity in the block is counted in sample periods, not in clock cycles. A spike qualifies as a tap only if it falls back below the threshold soon enough. A dead time then follows, during which samples are ignored. After the dead time, a search window opens in which a second spike on the same axis turns the event into a double tap.

Software programs the configuration inputs:

- the magnitude threshold;
- the longest allowed pulse;
- the dead time;
- the second-tap window;
- per-axis enables for single and double taps;
- the interrupt style.

When a tap is reported, the block records it in a source word and raises an interrupt. The interrupt is either a one-clock pulse or, in latched mode, a level that stays asserted until the source word is read. A read strobe clears the word.

Top module: `tap_detect`

## Requirements
- R1: An axis starts a pulse on a strobe when it is enabled (single or double) and its absolute value is strictly greater than `thresh`. A value equal to the threshold does not start a pulse. Negative values are judged by magnitude.
- R2: A pulse is a tap only if it lasts at most `tlimit` consecutive strobes above threshold on the captured axis. A longer pulse is dropped without any report, and the block waits for the axis to fall below threshold. With `tlimit` = 0 every pulse is dropped.
- R3: The `tlatency` strobes that follow the strobe ending a tap are ignored, whatever their sample values.
- R4: The window then runs for `twindow` strobes. If the captured axis, with double enabled, rises above threshold within the window and that second pulse ends within the limit, a double tap is reported on the strobe where it ends.
- R5: A single tap is reported in one of two cases. If double is enabled on the axis, it is reported on the strobe where the window expires, provided single is enabled. If double is not enabled on the axis, it is reported on the strobe that ends the pulse.
- R6: An axis with neither enable set is never captured. With all enables clear, no report is ever made.
- R7: `src_word` bits are: [0] X, [1] Y, [2] Z, [3] sign (1 = negative at pulse start), [4] single, [5] double, [6] active. When several axes start together, the lowest-numbered one (X, then Y, then Z) is captured.
- R8: With `latch_mode` = 0, `irq` is high for exactly the one clock after the strobe that produces a report.
- R9: With `latch_mode` = 1, `irq` follows the active bit. `src_rd` clears `src_word` to zero on the next clock. A report made in the same clock as a read wins over the clear.
- R10: State, counters and reports change only on clocks where `smp_valid` is high. Clocks without a strobe do not advance any count.
- R11: After reset, `irq` is 0 and `src_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-clock strobe marking a new sample |
| acc_x | input | DATA_W | Signed X sample |
| acc_y | input | DATA_W | Signed Y sample |
| acc_z | input | DATA_W | Signed Z sample |
| thresh | input | DATA_W | Unsigned magnitude threshold |
| tlimit | input | LIM_W | Longest pulse, in strobes |
| tlatency | input | LAT_W | Dead time after a tap, in strobes |
| twindow | input | WIN_W | Second-tap window, in strobes |
| single_en | input | 3 | Single-tap enable per axis (bit 0 = X) |
| double_en | input | 3 | Double-tap enable per axis (bit 0 = X) |
| latch_mode | input | 1 | 1 = level interrupt held until read |
| src_rd | input | 1 | Read strobe that clears the source word |
| irq | output | 1 | Interrupt |
| src_word | output | 7 | Source word of the last report |

## Verification
Errors in the internal sequencer are only visible through the reports it produces. If the strobe counter is off by one anywhere in the pulse, dead-time or window phases, a report moves by one strobe. It can also fail to appear, or a double tap can turn into a single tap. Each of these shows up at `irq` in the clock right after the affected strobe. If a wrong axis or sign is captured, it shows up as a bad flag in `src_word` on the reporting clock. A sequencer stuck outside its idle state shows up as missing reports for all later taps. The vector sequence therefore checks `irq` and `src_word` after every single strobe.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PULSE1 = 3'd1,
    ST_DEAD   = 3'd2,
    ST_WIN    = 3'd3,
    ST_PULSE2 = 3'd4,
    ST_DROP   = 3'd5
  } tap_state_e;

  localparam int unsigned NAX   = 3;
  localparam int unsigned SRC_W = 7;

  localparam int unsigned SB_SIGN   = 3;
  localparam int unsigned SB_SINGLE = 4;
  localparam int unsigned SB_DOUBLE = 5;
  localparam int unsigned SB_ACTIVE = 6;
endpackage

// File: rtl/tap_axis_cmp.sv
module tap_axis_cmp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] thresh,
  input  logic              enable,
  output logic              over,
  output logic              neg
);
  logic [DATA_W-1:0] mag;

  always_comb begin
    neg  = sample[DATA_W-1];
    mag  = neg ? (~sample + 1'b1) : sample;
    over = enable && (mag > thresh);
  end
endmodule

// File: rtl/tap_seq.sv
module tap_seq
  import tap_pkg::*;
#(
  parameter int unsigned LIM_W = 7,
  parameter int unsigned LAT_W = 8,
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [NAX-1:0]   over,
  input  logic [NAX-1:0]   neg,
  input  logic [LIM_W-1:0] tlimit,
  input  logic [LAT_W-1:0] tlatency,
  input  logic [WIN_W-1:0] twindow,
  input  logic [NAX-1:0]   single_en,
  input  logic [NAX-1:0]   double_en,
  output logic             ev_fire,
  output logic             ev_dbl,
  output logic [NAX-1:0]   ev_axis,
  output logic             ev_sign
);
  localparam int unsigned MAX_W = (LIM_W > LAT_W) ? ((LIM_W > WIN_W) ? LIM_W : WIN_W)
                                                  : ((LAT_W > WIN_W) ? LAT_W : WIN_W);
  localparam int unsigned CNT_W = MAX_W + 1;

  tap_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [NAX-1:0]   sel_q, sel_n;
  logic             sgn_q, sgn_n;

  logic [CNT_W-1:0] lim_ext, lat_ext, win_ext, cnt_inc;
  logic [NAX-1:0]   first;
  logic             cur_over, den_sel, sen_sel, go_post;

  always_comb begin
    lim_ext  = {{(CNT_W-LIM_W){1'b0}}, tlimit};
    lat_ext  = {{(CNT_W-LAT_W){1'b0}}, tlatency};
    win_ext  = {{(CNT_W-WIN_W){1'b0}}, twindow};
    cnt_inc  = cnt_q + 1'b1;
    first    = over & (~over + 1'b1);
    cur_over = |(over & sel_q);
    den_sel  = |(double_en & sel_q);
    sen_sel  = |(single_en & sel_q);
  end

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sel_n   = sel_q;
    sgn_n   = sgn_q;
    ev_fire = 1'b0;
    ev_dbl  = 1'b0;
    go_post = 1'b0;
    if (smp_valid) begin
      unique case (st_q)
        ST_IDLE: begin
          if (|over) begin
            sel_n = first;
            sgn_n = |(neg & first);
            cnt_n = {{(CNT_W-1){1'b0}}, 1'b1};
            st_n  = (tlimit == '0) ? ST_DROP : ST_PULSE1;
          end
        end
        ST_PULSE1: begin
          if (cur_over) begin
            if (cnt_q >= lim_ext) st_n = ST_DROP;
            else                  cnt_n = cnt_inc;
          end else begin
            if (!den_sel && sen_sel) ev_fire = 1'b1;
            cnt_n = '0;
            if (tlatency == '0) go_post = 1'b1;
            else                st_n = ST_DEAD;
          end
        end
        ST_DEAD: begin
          cnt_n = cnt_inc;
          if (cnt_inc == lat_ext) go_post = 1'b1;
        end
        ST_WIN: begin
          if (cur_over) begin
            cnt_n = {{(CNT_W-1){1'b0}}, 1'b1};
            st_n  = (tlimit == '0) ? ST_DROP : ST_PULSE2;
          end else begin
            cnt_n = cnt_inc;
            if (cnt_inc == win_ext) begin
              ev_fire = sen_sel;
              st_n    = ST_IDLE;
            end
          end
        end
        ST_PULSE2: begin
          if (cur_over) begin
            if (cnt_q >= lim_ext) st_n = ST_DROP;
            else                  cnt_n = cnt_inc;
          end else begin
            ev_fire = 1'b1;
            ev_dbl  = 1'b1;
            st_n    = ST_IDLE;
          end
        end
        ST_DROP: begin
          if (!cur_over) st_n = ST_IDLE;
        end
        default: st_n = ST_IDLE;
      endcase
      if (go_post) begin
        cnt_n = '0;
        if (den_sel && (twindow != '0)) begin
          st_n = ST_WIN;
        end else begin
          st_n = ST_IDLE;
          if (den_sel && sen_sel) ev_fire = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sel_q <= '0;
      sgn_q <= 1'b0;
    end else if (smp_valid) begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sel_q <= sel_n;
      sgn_q <= sgn_n;
    end
  end

  assign ev_axis = sel_q;
  assign ev_sign = sgn_q;
endmodule

// File: rtl/tap_report.sv
module tap_report
  import tap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_fire,
  input  logic             ev_dbl,
  input  logic [NAX-1:0]   ev_axis,
  input  logic             ev_sign,
  input  logic             latch_mode,
  input  logic             src_rd,
  output logic             irq,
  output logic [SRC_W-1:0] src_word
);
  logic [SRC_W-1:0] src_q, src_n;
  logic             pulse_q;
  logic             src_en;

  always_comb begin
    src_en = ev_fire || src_rd;
    src_n  = '0;
    if (ev_fire) begin
      src_n[NAX-1:0]   = ev_axis;
      src_n[SB_SIGN]   = ev_sign;
      src_n[SB_SINGLE] = !ev_dbl;
      src_n[SB_DOUBLE] = ev_dbl;
      src_n[SB_ACTIVE] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else if (src_en) begin
      src_q <= src_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= ev_fire;
  end

  assign irq      = latch_mode ? src_q[SB_ACTIVE] : pulse_q;
  assign src_word = src_q;
endmodule

// File: rtl/tap_detect.sv
module tap_detect
  import tap_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LIM_W  = 7,
  parameter int unsigned LAT_W  = 8,
  parameter int unsigned WIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] acc_x,
  input  logic [DATA_W-1:0] acc_y,
  input  logic [DATA_W-1:0] acc_z,
  input  logic [DATA_W-1:0] thresh,
  input  logic [LIM_W-1:0]  tlimit,
  input  logic [LAT_W-1:0]  tlatency,
  input  logic [WIN_W-1:0]  twindow,
  input  logic [2:0]        single_en,
  input  logic [2:0]        double_en,
  input  logic              latch_mode,
  input  logic              src_rd,
  output logic              irq,
  output logic [6:0]        src_word
);
  logic [DATA_W-1:0] smp [NAX];
  logic [NAX-1:0]    over, neg, axis_en;
  logic              ev_fire, ev_dbl, ev_sign;
  logic [NAX-1:0]    ev_axis;

  assign smp[0]  = acc_x;
  assign smp[1]  = acc_y;
  assign smp[2]  = acc_z;
  assign axis_en = single_en | double_en;

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    tap_axis_cmp #(.DATA_W(DATA_W)) u_cmp (
      .sample (smp[g]),
      .thresh (thresh),
      .enable (axis_en[g]),
      .over   (over[g]),
      .neg    (neg[g])
    );
  end

  tap_seq #(.LIM_W(LIM_W), .LAT_W(LAT_W), .WIN_W(WIN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .over      (over),
    .neg       (neg),
    .tlimit    (tlimit),
    .tlatency  (tlatency),
    .twindow   (twindow),
    .single_en (single_en),
    .double_en (double_en),
    .ev_fire   (ev_fire),
    .ev_dbl    (ev_dbl),
    .ev_axis   (ev_axis),
    .ev_sign   (ev_sign)
  );

  tap_report u_rep (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_fire    (ev_fire),
    .ev_dbl     (ev_dbl),
    .ev_axis    (ev_axis),
    .ev_sign    (ev_sign),
    .latch_mode (latch_mode),
    .src_rd     (src_rd),
    .irq        (irq),
    .src_word   (src_word)
  );
endmodule

// File: rtl/tap_detect_chk.sv
module tap_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_valid,
  input logic       latch_mode,
  input logic       src_rd,
  input logic       irq,
  input logic [6:0] src_word
);
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> src_word[6]); // R7
  AST_AXIS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    src_word[6] |-> $onehot0(src_word[2:0]) && (src_word[2:0] != 3'b000)); // R7
  AST_KIND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    src_word[6] |-> ($countones(src_word[5:4]) == 1)); // R7
  AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode && irq) |-> $past(smp_valid)); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && irq && !src_rd) |=> (irq || !latch_mode)); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd && !smp_valid) |=> (src_word == 7'd0)); // R9
  AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(smp_valid) && !$past(src_rd)) |-> $stable(src_word)); // R10
endmodule

bind tap_detect tap_detect_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .latch_mode (latch_mode),
  .src_rd     (src_rd),
  .irq        (irq),
  .src_word   (src_word)
);

// File: tb/tb_tap_detect.sv
module tb_tap_detect;
  logic              clk;
  logic              rst_n;
  logic              smp_valid;
  logic [15:0]       acc_x, acc_y, acc_z;
  logic [15:0]       thresh;
  logic [6:0]        tlimit;
  logic [7:0]        tlatency, twindow;
  logic [2:0]        single_en, double_en;
  logic              latch_mode, src_rd;
  logic              irq;
  logic [6:0]        src_word;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  tap_detect dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
    .thresh(thresh), .tlimit(tlimit), .tlatency(tlatency), .twindow(twindow),
    .single_en(single_en), .double_en(double_en),
    .latch_mode(latch_mode), .src_rd(src_rd),
    .irq(irq), .src_word(src_word)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // entry: x, y, z, expected irq, expected src_word
  localparam logic [55:0] VEC [0:28] = '{
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h00}, // idle
    {16'sd0,      16'sd2000, 16'sd0,     1'b0, 7'h00}, // R1 Y starts
    {16'sd0,      16'sd1500, 16'sd0,     1'b0, 7'h00},
    {16'sd0,      16'sd0,    16'sd0,     1'b1, 7'h52}, // R5 single, no double on Y
    {16'sd0,      16'sd3000, 16'sd0,     1'b0, 7'h52}, // R3 ignored
    {16'sd0,      16'sd3000, 16'sd0,     1'b0, 7'h52}, // R3 ignored
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h52},
    {-16'sd1200,  16'sd0,    16'sd0,     1'b0, 7'h52}, // R1 negative X
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h52},
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h52},
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h52},
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h52},
    {16'sd1500,   16'sd0,    16'sd0,     1'b0, 7'h52}, // R4 second tap
    {16'sd0,      16'sd0,    16'sd0,     1'b1, 7'h69}, // R4 double
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h69}, // R8 pulse ended
    {16'sd0,      16'sd0,   -16'sd5000,  1'b0, 7'h69},
    {16'sd0,      16'sd0,   -16'sd5000,  1'b0, 7'h69},
    {16'sd0,      16'sd0,   -16'sd5000,  1'b0, 7'h69},
    {16'sd0,      16'sd0,   -16'sd5000,  1'b0, 7'h69}, // R2 too long
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h69}, // R2 dropped
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h69},
    {16'sd1100,   16'sd0,    16'sd0,     1'b0, 7'h69},
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h69},
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h69},
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h69},
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h69},
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h69},
    {16'sd0,      16'sd0,    16'sd0,     1'b1, 7'h51}, // R5 window expiry
    {16'sd0,      16'sd0,    16'sd0,     1'b0, 7'h51}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    acc_x = x; acc_y = y; acc_z = z;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic config_set(input logic [6:0] lim, input logic [7:0] lat, input logic [7:0] win,
                            input logic [2:0] sen, input logic [2:0] den, input logic lm);
    tlimit = lim; tlatency = lat; twindow = win;
    single_en = sen; double_en = den; latch_mode = lm;
  endtask

  task automatic do_read();
    src_rd = 1'b1;
    @(negedge clk);
    src_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; src_rd = 1'b0;
    acc_x = '0; acc_y = '0; acc_z = '0;
    thresh = 16'd1000;
    config_set(7'd3, 8'd2, 8'd3, 3'b111, 3'b001, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 irq", {7'd0, irq}, 8'd0);
    check("R11 src", {1'b0, src_word}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 29; i++) begin
      strobe(VEC[i][55:40], VEC[i][39:24], VEC[i][23:8]);
      check($sformatf("R4/R5 vec%0d irq", i), {7'd0, irq}, {7'd0, VEC[i][7]});
      check($sformatf("R7 vec%0d src", i), {1'b0, src_word}, {1'b0, VEC[i][6:0]});
    end

    // R1: equal to threshold does not start; R6: empty enables
    config_set(7'd3, 8'd0, 8'd0, 3'b111, 3'b000, 1'b0);
    strobe(16'd1000, -16'sd1000, 16'd1000);
    strobe(16'd0, 16'd0, 16'd0);
    check("R1 equal threshold irq", {7'd0, irq}, 8'd0);
    check("R1 equal threshold src", {1'b0, src_word}, 8'h51);
    config_set(7'd3, 8'd0, 8'd0, 3'b000, 3'b000, 1'b0);
    strobe(16'd5000, 16'd5000, 16'd5000);
    check("R6 disabled irq a", {7'd0, irq}, 8'd0);
    strobe(16'd0, 16'd0, 16'd0);
    check("R6 disabled irq b", {7'd0, irq}, 8'd0);
    check("R6 disabled src", {1'b0, src_word}, 8'h51);

    // R2: limit zero drops every pulse
    config_set(7'd0, 8'd0, 8'd0, 3'b111, 3'b000, 1'b0);
    strobe(16'd2000, 16'd0, 16'd0);
    strobe(16'd0, 16'd0, 16'd0);
    check("R2 limit0 irq", {7'd0, irq}, 8'd0);
    strobe(16'd0, 16'd0, 16'd0);
    check("R2 limit0 src", {1'b0, src_word}, 8'h51);

    // R7 priority and sign: Y and Z together, Y negative
    config_set(7'd3, 8'd0, 8'd0, 3'b111, 3'b000, 1'b0);
    strobe(16'd0, -16'sd2000, 16'd3000);
    strobe(16'd0, 16'd0, 16'd0);
    check("R7 priority irq", {7'd0, irq}, 8'd1);
    check("R7 priority src", {1'b0, src_word}, 8'h5A);

    // R10: idle clocks do not advance the window
    config_set(7'd3, 8'd0, 8'd3, 3'b001, 3'b001, 1'b0);
    strobe(16'd1500, 16'd0, 16'd0);
    strobe(16'd0, 16'd0, 16'd0);
    repeat (40) @(negedge clk);
    check("R10 no strobe irq", {7'd0, irq}, 8'd0);
    strobe(16'd0, 16'd0, 16'd0);
    strobe(16'd0, 16'd0, 16'd0);
    check("R10 window not early", {7'd0, irq}, 8'd0);
    strobe(16'd0, 16'd0, 16'd0);
    check("R10 window expiry irq", {7'd0, irq}, 8'd1);
    check("R5 window expiry src", {1'b0, src_word}, 8'h51);

    // R9: latched mode holds until read
    config_set(7'd3, 8'd0, 8'd0, 3'b010, 3'b000, 1'b1);
    do_read();
    check("R9 read clears", {1'b0, src_word}, 8'h00);
    strobe(16'd0, 16'd2000, 16'd0);
    strobe(16'd0, 16'd0, 16'd0);
    check("R9 latched irq set", {7'd0, irq}, 8'd1);
    repeat (5) @(negedge clk);
    strobe(16'd0, 16'd0, 16'd0);
    strobe(16'd0, 16'd0, 16'd0);
    check("R9 latched irq held", {7'd0, irq}, 8'd1);
    check("R9 latched src held", {1'b0, src_word}, 8'h52);
    do_read();
    check("R9 irq after read", {7'd0, irq}, 8'd0);
    check("R9 src after read", {1'b0, src_word}, 8'h00);

    // R9: report in the same clock as a read wins
    strobe(16'd0, 16'd2000, 16'd0);
    src_rd = 1'b1;
    strobe(16'd0, 16'd0, 16'd0);
    src_rd = 1'b0;
    check("R9 event beats read irq", {7'd0, irq}, 8'd1);
    check("R9 event beats read src", {1'b0, src_word}, 8'h52);

    done = 1;
    finish_run();
  end
endmodule